// File: doc/BRIEF.md
# Step Attenuator Serial Write Controller

This block sits on the host side of a serially programmed RF step attenuator. A client hands it a 6-bit attenuation code through a valid/ready handshake. The block shifts the code out on a three-wire link made of a serial clock, a data line and a latch strobe. The receiving shift register samples on the rising serial clock edge. The strobe stays low during the shift, so the attenuator keeps its old setting while the new bits arrive. After the last falling clock edge the strobe goes high once, and when it returns low the new code takes effect.

Every analog timing limit is a parameter in nanoseconds. The limits are clock high and low time, clock period, data setup and hold, strobe setup and strobe width, and the minimum spacing between updates. Each one is turned into a count of system clock cycles, rounded up. The block reports busy while a write is in progress. It raises a one-cycle done pulse when the write finishes and the update-spacing guard has run out. The serial clock rests low.

Top module: `atten_serial_master`

## Requirements
- R1: A code is accepted only on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle. The code is captured at acceptance, so later changes on `in_word`, and `in_valid` pulses made while busy, do not change what is sent. Each accepted request produces exactly one strobe pulse.
- R2: The six bits go out most significant first, so bit 5 (the largest step) comes first and bit 0 (the smallest step) comes last. A receiver that samples `ser_data` on each rising `ser_clk` edge and latches its register when `ser_le` falls holds exactly the accepted code.
- R3: `ser_le` is low on every cycle in which `ser_clk` is high.
- R4: Every high phase of `ser_clk` lasts at least ceil(SCLK_HIGH_NS/CLK_NS) cycles. Every low phase between two rising edges of one write lasts at least ceil(SCLK_LOW_NS/CLK_NS) cycles. Successive rising edges are at least ceil(SCLK_PERIOD_NS/CLK_NS) cycles apart.
- R5: `ser_data` changes only while `ser_clk` is low. It changes at least ceil(DATA_HOLD_NS/CLK_NS) cycles after the preceding falling edge, and at least ceil(DATA_SETUP_NS/CLK_NS) cycles before the next rising edge.
- R6: `ser_le` rises at least ceil(LE_SETUP_NS/CLK_NS) cycles after the last falling `ser_clk` edge. It stays high for at least ceil(LE_WIDTH_NS/CLK_NS) cycles.
- R7: Two successive rising edges of `ser_le` are at least ceil(UPDATE_NS/CLK_NS) cycles apart, even when requests arrive back to back.
- R8: `done` is high for exactly one cycle at the end of each write. On the following cycle the block is idle with `in_ready` high.
- R9: While `rst` is high, `ser_clk`, `ser_data`, `ser_le`, `busy` and `done` are low and `in_ready` is high.
- R10: Each write produces exactly six rising `ser_clk` edges before its strobe pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe for a new attenuation code |
| in_ready | output | 1 | High when a request can be accepted |
| in_word | input | WORD_W | Attenuation code to send |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-cycle pulse at the end of a write |
| ser_clk | output | 1 | Serial clock to the attenuator, resting low |
| ser_data | output | 1 | Serial data to the attenuator |
| ser_le | output | 1 | Latch strobe to the attenuator |

## Verification
The bench sends all 64 codes through a model of the receiving shift register and latch. An error in bit order or bit count shows up as a wrong latched code or a wrong number of rising clock edges. A data line that moves too close to a clock edge, or a strobe that rises before the last falling edge, breaks one of the measured minimums. The same is true of a phase or pulse width off by one cycle. Some requests change the input word after acceptance, or pulse `in_valid` while busy. A design that captured late or accepted while busy would latch a different code or produce two strobes. Requests are issued back to back, which exposes a guard interval that is too short as strobe rises that come too close together.

// File: rtl/atten_ser_pkg.sv
package atten_ser_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT_LOW,
        ST_SHIFT_HIGH,
        ST_LE_SETUP,
        ST_LE_PULSE,
        ST_GUARD,
        ST_DONE
    } ser_state_e;

    typedef struct packed {
        logic sclk;
        logic sdata;
        logic le;
    } ser_pins_t;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asp_phase_timer.sv
module asp_phase_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic [TW-1:0] count,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign count   = cnt_q;
    assign expired = (cnt_q == '0);

    // Phase lengths (R4) rely on a strict one-per-cycle countdown.
    assert_countdown_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/asp_word_shifter.sv
module asp_word_shifter #(
    parameter int WORD_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [WORD_W-1:0] word_in,
    input  logic              shift,
    output logic              msb,
    output logic              last
);

    localparam int IW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(WORD_W - 1);

    logic [WORD_W-1:0] sh_q;
    logic [IW-1:0]     idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (capture) begin
            sh_q  <= word_in;
            idx_q <= '0;
        end else if (shift) begin
            sh_q  <= sh_q << 1;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign msb  = sh_q[WORD_W-1];
    assign last = (idx_q == LAST_IDX);

    // Only six bits per write: the index never runs past the last bit.
    assert_index_bounded_R10: assert property (@(posedge clk) disable iff (rst)
        (shift && !capture) |-> (idx_q != LAST_IDX));

endmodule

// File: rtl/atten_serial_master.sv
module atten_serial_master
    import atten_ser_pkg::*;
#(
    parameter int WORD_W         = 6,
    parameter int CLK_NS         = 10,
    parameter int SCLK_HIGH_NS   = 30,
    parameter int SCLK_LOW_NS    = 30,
    parameter int SCLK_PERIOD_NS = 100,
    parameter int DATA_SETUP_NS  = 10,
    parameter int DATA_HOLD_NS   = 10,
    parameter int LE_SETUP_NS    = 10,
    parameter int LE_WIDTH_NS    = 30,
    parameter int UPDATE_NS      = 40000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              busy,
    output logic              done,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_le
);

    localparam int HI_C   = ns_to_cycles(SCLK_HIGH_NS, CLK_NS);
    localparam int PER_C  = ns_to_cycles(SCLK_PERIOD_NS, CLK_NS);
    localparam int SU_C   = ns_to_cycles(DATA_SETUP_NS, CLK_NS);
    localparam int HD_C   = ns_to_cycles(DATA_HOLD_NS, CLK_NS);
    localparam int LO_C   = max2(max2(ns_to_cycles(SCLK_LOW_NS, CLK_NS), SU_C + HD_C),
                                 PER_C - HI_C);
    localparam int LESU_C = ns_to_cycles(LE_SETUP_NS, CLK_NS);
    localparam int LEPW_C = ns_to_cycles(LE_WIDTH_NS, CLK_NS);
    localparam int GD_C   = ns_to_cycles(UPDATE_NS, CLK_NS);
    localparam int MAX_C  = max2(max2(max2(HI_C, LO_C), max2(LESU_C, LEPW_C)), GD_C);
    localparam int TW     = $clog2(MAX_C + 1);

    localparam logic [TW-1:0] HOLD_MARK = TW'(LO_C - HD_C);

    ser_state_e    state_q;
    ser_pins_t     pins_q;
    logic          done_q;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic [TW-1:0] tmr_cnt;
    logic          tmr_exp;
    logic          cap;
    logic          shf;
    logic          sh_msb;
    logic          sh_last;

    asp_phase_timer #(.TW(TW)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .count    (tmr_cnt),
        .expired  (tmr_exp)
    );

    asp_word_shifter #(.WORD_W(WORD_W)) i_shifter (
        .clk     (clk),
        .rst     (rst),
        .capture (cap),
        .word_in (in_word),
        .shift   (shf),
        .msb     (sh_msb),
        .last    (sh_last)
    );

    // Phase sequencing: which timer load and datapath step fire this cycle.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap      = 1'b0;
        shf      = 1'b0;
        unique case (state_q)
            ST_IDLE: if (in_valid) begin
                cap      = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = TW'(LO_C - 1);
            end
            ST_SHIFT_LOW: if (tmr_exp) begin
                tmr_load = 1'b1;
                tmr_val  = TW'(HI_C - 1);
            end
            ST_SHIFT_HIGH: if (tmr_exp) begin
                tmr_load = 1'b1;
                if (sh_last) begin
                    tmr_val = TW'(LESU_C - 1);
                end else begin
                    shf     = 1'b1;
                    tmr_val = TW'(LO_C - 1);
                end
            end
            ST_LE_SETUP: if (tmr_exp) begin
                tmr_load = 1'b1;
                tmr_val  = TW'(LEPW_C - 1);
            end
            ST_LE_PULSE: if (tmr_exp) begin
                tmr_load = 1'b1;
                tmr_val  = TW'(GD_C - 1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pins_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (in_valid) begin
                    pins_q.sdata <= in_word[WORD_W-1];
                    state_q      <= ST_SHIFT_LOW;
                end
                ST_SHIFT_LOW: begin
                    if (tmr_cnt == HOLD_MARK)
                        pins_q.sdata <= sh_msb;
                    if (tmr_exp) begin
                        pins_q.sclk <= 1'b1;
                        state_q     <= ST_SHIFT_HIGH;
                    end
                end
                ST_SHIFT_HIGH: if (tmr_exp) begin
                    pins_q.sclk <= 1'b0;
                    state_q     <= sh_last ? ST_LE_SETUP : ST_SHIFT_LOW;
                end
                ST_LE_SETUP: if (tmr_exp) begin
                    pins_q.le <= 1'b1;
                    state_q   <= ST_LE_PULSE;
                end
                ST_LE_PULSE: if (tmr_exp) begin
                    pins_q.le <= 1'b0;
                    state_q   <= ST_GUARD;
                end
                ST_GUARD: if (tmr_exp) begin
                    done_q  <= 1'b1;
                    state_q <= ST_DONE;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign in_ready = (state_q == ST_IDLE);
    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign ser_clk  = pins_q.sclk;
    assign ser_data = pins_q.sdata;
    assign ser_le   = pins_q.le;

    assert_accept_starts_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (busy && !ser_le && !ser_clk));

    assert_le_quiet_shift_R3: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> !ser_le);

    assert_data_steady_high_R5: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> $stable(ser_data));

    assert_data_hold_fall_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_clk) |-> $stable(ser_data));

    assert_le_after_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_le) |-> (!ser_clk && $past(!ser_clk)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && in_ready));

endmodule

// File: tb/test_atten_serial_master.sv
module test_atten_serial_master;

    localparam int CLK_NS  = 10;
    localparam int UPD_NS  = 2000;
    localparam int E_HI    = (30 + CLK_NS - 1) / CLK_NS;
    localparam int E_LO    = (30 + CLK_NS - 1) / CLK_NS;
    localparam int E_PER   = (100 + CLK_NS - 1) / CLK_NS;
    localparam int E_SU    = (10 + CLK_NS - 1) / CLK_NS;
    localparam int E_HD    = (10 + CLK_NS - 1) / CLK_NS;
    localparam int E_LESU  = (10 + CLK_NS - 1) / CLK_NS;
    localparam int E_LEPW  = (30 + CLK_NS - 1) / CLK_NS;
    localparam int E_UPD   = (UPD_NS + CLK_NS - 1) / CLK_NS;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic       in_ready;
    logic [5:0] in_word;
    logic       busy;
    logic       done;
    logic       ser_clk;
    logic       ser_data;
    logic       ser_le;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    atten_serial_master #(
        .WORD_W (6),
        .CLK_NS (CLK_NS),
        .UPDATE_NS (UPD_NS)
    ) i_atten_serial_master (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_word  (in_word),
        .busy     (busy),
        .done     (done),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .ser_le   (ser_le)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Receiver model plus timing monitor, sampled on the falling clock.
    logic [5:0] rx_sr = '0;
    logic [5:0] rx_latched = '0;
    logic [5:0] exp_word = '0;
    logic p_sclk = 1'b0, p_sdata = 1'b0, p_le = 1'b0;
    int n = 0;
    int t_rise = -100000, t_fall = -100000, t_data = -100000;
    int t_le_rise = -100000;
    int rises = 0;
    int le_pulses = 0;
    bit fall_in_write = 1'b0;
    bit had_le = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            n++;
            if (ser_data != p_sdata) begin
                chk(!ser_clk, "R5 data moves only with clock low", ser_clk, 0);
                chk(n - t_fall >= E_HD, "R5 hold after fall", n - t_fall, E_HD);
                t_data = n;
            end
            if (ser_clk && !p_sclk) begin
                chk(!ser_le, "R3 strobe low at rising clock", ser_le, 0);
                chk(n - t_data >= E_SU, "R5 setup before rise", n - t_data, E_SU);
                if (fall_in_write)
                    chk(n - t_fall >= E_LO, "R4 low time", n - t_fall, E_LO);
                if (rises > 0)
                    chk(n - t_rise >= E_PER, "R4 clock period", n - t_rise, E_PER);
                rx_sr = {rx_sr[4:0], ser_data};
                rises++;
                t_rise = n;
            end
            if (!ser_clk && p_sclk) begin
                chk(n - t_rise >= E_HI, "R4 high time", n - t_rise, E_HI);
                t_fall = n;
                fall_in_write = 1'b1;
            end
            if (ser_le && !p_le) begin
                chk(n - t_fall >= E_LESU, "R6 strobe setup", n - t_fall, E_LESU);
                chk(rises == 6, "R10 rising edges per write", rises, 6);
                if (had_le)
                    chk(n - t_le_rise >= E_UPD, "R7 update spacing", n - t_le_rise, E_UPD);
                t_le_rise = n;
                had_le = 1'b1;
                le_pulses++;
            end
            if (!ser_le && p_le) begin
                chk(n - t_le_rise >= E_LEPW, "R6 strobe width", n - t_le_rise, E_LEPW);
                rx_latched = rx_sr;
                chk(rx_sr == exp_word, "R2 latched code", rx_sr, exp_word);
                rises = 0;
                fall_in_write = 1'b0;
            end
        end
        p_sclk  = ser_clk;
        p_sdata = ser_data;
        p_le    = ser_le;
    end

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        in_word  = '0;
        repeat (3) @(negedge clk);
        chk(!ser_clk && !ser_data && !ser_le, "R9 pins low in reset",
            {ser_clk, ser_data, ser_le}, 0);
        chk(!busy && !done, "R9 busy and done low in reset", {busy, done}, 0);
        chk(in_ready, "R9 ready high in reset", in_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        for (int w = 0; w < 64; w++) begin
            while (!in_ready) @(negedge clk);
            in_valid  = 1'b1;
            in_word   = 6'(w);
            exp_word  = 6'(w);
            le_pulses = 0;
            @(negedge clk);
            chk(busy && !in_ready, "R1 accepted request starts write", {busy, in_ready}, 2);
            in_valid = 1'b0;
            in_word  = ~6'(w);
            if (w % 4 == 1) begin
                repeat (5) @(negedge clk);
                in_valid = 1'b1;
                in_word  = 6'(w) ^ 6'h2A;
                @(negedge clk);
                in_valid = 1'b0;
            end
            while (!done) @(negedge clk);
            chk(!in_ready, "R8 not ready while done", in_ready, 0);
            @(negedge clk);
            chk(!done, "R8 done lasts one cycle", done, 0);
            chk(in_ready && !busy, "R8 idle after done", {in_ready, busy}, 2);
            chk(le_pulses == 1, "R1 one strobe per request", le_pulses, 1);
            chk(rx_latched == 6'(w), "R2 receiver holds code", rx_latched, w);
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
            $finish;
        end
    end

endmodule